// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a host with a simple request/acknowledge handshake to an external 128K x 8 asynchronous static RAM. The host presents a request flag, a write flag, a 17-bit byte address and an 8-bit write value. The controller runs one RAM access and answers with a one-cycle acknowledge. For reads, the byte fetched from the RAM comes back with the acknowledge. The RAM side consists of a 17-bit address, a chip-select pair (one active-low select, one active-high select), an active-low read-enable strobe, an active-low write strobe and a shared bidirectional 8-bit data bus. The controller owns the tri-state driver for that bus.

Every RAM timing rule is expressed in the RAM's own units: read cycle, address access, write cycle, write pulse width and data setup. All of these are parameters in nanoseconds, together with the clock period. At elaboration each is turned into a whole number of clock cycles by ceiling division, with a minimum of one. All RAM-side signals come straight from registers, so strobe edges line up with clock edges. Every write is ended by the write strobe rising while the chip stays selected. The read strobe stays high for the whole write, so the RAM never drives the bus during a write. After a read there is always a released cycle before the controller drives the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both selects are inactive (`ram_sel_n`=1, `ram_sel_p`=0), `ram_rd_en_n`=1, `ram_wr_n`=1, `host_ack`=0 and the controller does not drive `ram_dq`.
- R2: The selects are active (`ram_sel_n`=0 and `ram_sel_p`=1) from the clock edge that accepts a request through the last cycle of that access. In every other cycle, including idle cycles with no request, both are inactive.
- R3: A read (`host_wr`=0) holds `ram_rd_en_n` low and `ram_wr_n` high for RD_LEN = max(ceil(T_RC/T_CLK), ceil(T_AA/T_CLK)) cycles, each term at least 1, with the selects active for the same window. `host_rdata` takes the value on `ram_dq` in the last cycle of that window and is valid in the cycle `host_ack` is high.
- R4: A write (`host_wr`=1) drives `host_wdata` onto `ram_dq` and pulls `ram_wr_n` low from the same edge. The strobe stays low for WE_LOW = max(ceil(T_WP/T_CLK), ceil(T_DW/T_CLK)) cycles, and `ram_addr` does not change while it is low.
- R5: A write lasts WR_LEN = max(ceil(T_WC/T_CLK), WE_LOW+1) cycles. In the cycles after `ram_wr_n` rises, the address, the selects and the driven data are held unchanged, so hold after the strobe is at least one cycle. The address never changes while the selects are active.
- R6: `ram_rd_en_n` stays high for the whole of a write, and the controller drives `ram_dq` only during a write, never while `ram_rd_en_n` is low.
- R7: Between the rise of `ram_rd_en_n` at the end of a read and the first cycle in which the controller drives `ram_dq`, there is at least one full clock cycle with the bus released.
- R8: `host_ack` is high for exactly one cycle per access, in the cycle after the access ends. A request still present during that acknowledge cycle is not accepted. Changes to `host_addr`, `host_wdata` or `host_wr` after the accepting edge have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address of the access |
| host_wdata | input | 8 | Byte to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte read, valid with host_ack |
| ram_addr | output | 17 | RAM address |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel_p | output | 1 | Active-high chip select |
| ram_rd_en_n | output | 1 | Active-low RAM output enable |
| ram_wr_n | output | 1 | Active-low RAM write strobe |
| ram_dq | inout | 8 | Shared RAM data bus |

## Verification
The hardest situation to reach is a change of bus owner: a read whose RAM drive has only just stopped, followed at once by a write that turns the controller's driver on. Two cases are hardest to see. One is a request flag still high during the acknowledge cycle, which must not start a second access. The other is host fields that change in the middle of an access. The stimulus runs reads and writes back to back, keeps the request high through the acknowledge on alternate accesses, and scrambles the address, data and direction right after each accepting edge. A bench RAM model timestamps every strobe, address and data change and checks the pulse, setup, access and turnaround times in nanoseconds. It uses slow timing parameters, so that every window spans several clocks and the data-setup term, not the pulse width, sets the strobe length.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_READ    = 2'd1,
        PH_WR_LOW  = 2'd2,
        PH_WR_TAIL = 2'd3
    } phase_e;

    // Timing rule in ns -> whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_downcnt.sv
module sram_ctrl_downcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int RD_LEN  = 1,
    parameter int WE_LOW  = 1,
    parameter int WR_TAIL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data,
    input  logic [DATA_W-1:0] bus_in
);

    localparam int LONGEST = imax(imax(RD_LEN, WE_LOW), WR_TAIL);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              sel;
        logic              rd_n;
        logic              wr_n;
        logic              drv;
        logic              ack;
    } seq_t;

    seq_t             st_d, st_q;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    sram_ctrl_downcnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (st_q.ph)
            PH_IDLE: begin
                // a request still high during the ack cycle is the old one
                if (host_req && !st_q.ack) begin
                    st_d.addr = host_addr;
                    st_d.sel  = 1'b1;
                    cnt_load  = 1'b1;
                    if (host_wr) begin
                        st_d.ph   = PH_WR_LOW;
                        st_d.wr_n = 1'b0;
                        st_d.drv  = 1'b1;
                        st_d.wdat = host_wdata;
                        cnt_val   = CNT_W'(WE_LOW - 1);
                    end else begin
                        st_d.ph   = PH_READ;
                        st_d.rd_n = 1'b0;
                        cnt_val   = CNT_W'(RD_LEN - 1);
                    end
                end
            end
            PH_READ: begin
                if (cnt_zero) begin
                    st_d.rdat = bus_in;
                    st_d.rd_n = 1'b1;
                    st_d.sel  = 1'b0;
                    st_d.ack  = 1'b1;
                    st_d.ph   = PH_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_WR_LOW: begin
                if (cnt_zero) begin
                    st_d.wr_n = 1'b1;
                    st_d.ph   = PH_WR_TAIL;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(WR_TAIL - 1);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_WR_TAIL: begin
                if (cnt_zero) begin
                    st_d.sel = 1'b0;
                    st_d.drv = 1'b0;
                    st_d.ack = 1'b1;
                    st_d.ph  = PH_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, addr: '0, wdat: '0, rdat: '0,
                      sel: 1'b0, rd_n: 1'b1, wr_n: 1'b1, drv: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign host_ack   = st_q.ack;
    assign host_rdata = st_q.rdat;
    assign mem_addr   = st_q.addr;
    assign mem_sel    = st_q.sel;
    assign mem_rd_n   = st_q.rd_n;
    assign mem_wr_n   = st_q.wr_n;
    assign drv_en     = st_q.drv;
    assign drv_data   = st_q.wdat;

    // strobe run-length counters used only by the checks below
    int rd_run_q, wr_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_run_q <= 0;
            wr_run_q <= 0;
        end else begin
            rd_run_q <= st_q.rd_n ? 0 : rd_run_q + 1;
            wr_run_q <= st_q.wr_n ? 0 : wr_run_q + 1;
        end
    end

    p_read_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rd_n) |-> (rd_run_q == RD_LEN));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wr_n) |-> (wr_run_q == WE_LOW));

    p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wr_n) |-> (st_q.sel && st_q.drv));

    p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel && $past(st_q.sel)) |-> $stable(st_q.addr));

    p_no_read_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.wr_n |-> st_q.rd_n);

    p_drive_only_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drv |-> st_q.rd_n);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.drv) |-> $past(st_q.rd_n));

    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |=> !st_q.ack);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 20,
    parameter int T_RC_NS = 20,
    parameter int T_AA_NS = 20,
    parameter int T_WC_NS = 20,
    parameter int T_WP_NS = 15,
    parameter int T_DW_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel_p,
    output logic              ram_rd_en_n,
    output logic              ram_wr_n,
    inout  wire  [DATA_W-1:0] ram_dq
);

    localparam int RD_LEN  = imax(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_AA_NS, CLK_NS));
    localparam int WE_LOW  = imax(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_DW_NS, CLK_NS));
    localparam int WR_LEN  = imax(ns_to_cycles(T_WC_NS, CLK_NS), WE_LOW + 1);
    localparam int WR_TAIL = WR_LEN - WE_LOW;

    logic              sel;
    logic              drv_en;
    logic [DATA_W-1:0] drv_data;

    sram_ctrl_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RD_LEN  (RD_LEN),
        .WE_LOW  (WE_LOW),
        .WR_TAIL (WR_TAIL)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .mem_addr   (ram_addr),
        .mem_sel    (sel),
        .mem_rd_n   (ram_rd_en_n),
        .mem_wr_n   (ram_wr_n),
        .drv_en     (drv_en),
        .drv_data   (drv_data),
        .bus_in     (ram_dq)
    );

    assign ram_sel_n = ~sel;
    assign ram_sel_p = sel;
    assign ram_dq    = drv_en ? drv_data : {DATA_W{1'bz}};

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel_n |-> (!drv_en && ram_rd_en_n && ram_wr_n));

    p_strobe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_rd_en_n || !ram_wr_n) |-> (!ram_sel_n && ram_sel_p));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

    // Slow grade so every window spans several clocks.
    localparam int CLK_NS = 20;
    localparam int T_RC = 45, T_AA = 55, T_WC = 95, T_WP = 35, T_DW = 45;
    // R3: max(ceil(45/20), ceil(55/20)) = 3
    localparam int RD_LEN = 3;
    // R4: max(ceil(35/20), ceil(45/20)) = 3
    localparam int WE_LOW = 3;
    // R5: max(ceil(95/20), 3+1) = 5
    localparam int WR_LEN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [16:0] ma;
    logic        s_n, s_p, oen, wen;
    wire  [7:0]  dq;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl #(
        .CLK_NS (CLK_NS), .T_RC_NS (T_RC), .T_AA_NS (T_AA),
        .T_WC_NS (T_WC), .T_WP_NS (T_WP), .T_DW_NS (T_DW)
    ) i_sram_async_ctrl (
        .clk (clk), .rst_n (rst_n),
        .host_req (req), .host_wr (wr), .host_addr (addr), .host_wdata (wdata),
        .host_ack (ack), .host_rdata (rdata),
        .ram_addr (ma), .ram_sel_n (s_n), .ram_sel_p (s_p),
        .ram_rd_en_n (oen), .ram_wr_n (wen), .ram_dq (dq)
    );

    int nchk = 0;
    int nfail = 0;
    bit armed = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fill(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
    endfunction

    // ---------------- RAM model with timing checks ----------------
    logic [7:0] ram [int];
    logic [7:0] mval;
    logic       sel;
    logic       mdrv;
    time        t_wf = 0, t_oef = 0, t_oer = 0, t_dq = 0, t_ma = 0, t_selr = 0;

    assign sel  = !s_n && s_p;
    assign mdrv = sel && wen && !oen;
    assign dq   = mdrv ? mval : 8'hzz;

    always @(ma or oen or wen or s_n or s_p) mval = ram.exists(ma) ? ram[ma] : fill(ma);
    always @(dq) t_dq = $time;
    always @(ma) t_ma = $time;
    always @(posedge sel) t_selr = $time;
    always @(negedge oen) t_oef = $time;

    always @(posedge oen) if (armed) begin
        t_oer = $time;
        check(($time - t_oef) >= T_AA, "R3", "read strobe width ns", int'($time - t_oef), T_AA);
    end

    always @(negedge wen) if (armed) begin
        t_wf = $time;
        check(oen == 1'b1, "R6", "read strobe during write", oen, 1);
        check(($time - t_oer) >= CLK_NS, "R7", "read end to drive gap ns", int'($time - t_oer), CLK_NS);
    end

    always @(posedge wen) if (armed) begin
        check(($time - t_wf) >= T_WP, "R4", "write pulse ns", int'($time - t_wf), T_WP);
        check(($time - t_dq) >= T_DW, "R4", "data setup ns", int'($time - t_dq), T_DW);
        check(t_ma <= t_wf, "R4", "address moved in pulse", int'(t_ma), int'(t_wf));
        check(oen == 1'b1, "R6", "read strobe at write end", oen, 1);
        ram[ma] = dq;
    end

    always @(negedge sel) if (armed) begin
        if (t_wf >= t_selr)
            check(($time - t_selr) >= T_WC, "R5", "write cycle ns", int'($time - t_selr), T_WC);
        else
            check(($time - t_selr) >= T_RC, "R3", "read cycle ns", int'($time - t_selr), T_RC);
        check(t_ma <= t_selr, "R5", "address moved while selected", int'(t_ma), int'(t_selr));
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        logic [16:0] a;
        logic [7:0]  exp;
    } sb_item_t;

    sb_item_t    sbq [$];
    logic [7:0]  shadow [int];
    logic        prev_ack = 1'b0;

    always @(negedge clk) if (armed) begin
        if (ack) begin
            check(!prev_ack, "R8", "ack longer than one cycle", prev_ack, 0);
            if (sbq.size() == 0) begin
                check(1'b0, "R8", "ack with nothing pending", 1, 0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (it.rd) check(rdata == it.exp, "R3", "read data", rdata, it.exp);
            end
        end
        prev_ack = ack;
    end

    // ---------------- driver ----------------
    task automatic access(input bit is_wr, input logic [16:0] a,
                          input logic [7:0] d, input bit hold);
        int len;
        sb_item_t it;
        len   = is_wr ? WR_LEN : RD_LEN;
        it.rd = !is_wr;
        it.a  = a;
        if (is_wr) begin
            shadow[a] = d;
            it.exp    = d;
        end else begin
            it.exp = shadow.exists(a) ? shadow[a] : fill(a);
        end
        sbq.push_back(it);
        req = 1'b1; wr = is_wr; addr = a; wdata = d;
        for (int k = 1; k <= len + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                // R8: fields after acceptance must be ignored
                addr = ~a; wdata = ~d; wr = !is_wr;
                if (!hold) req = 1'b0;
            end
            if (k <= len) begin
                check(!s_n && s_p, "R2", "selects during access", {s_n, s_p}, 2'b01);
                check(ma == a, "R8", "address held", ma, a);
                check(!ack, "R8", "early ack", ack, 0);
                if (is_wr) begin
                    check(oen, "R6", "read strobe in write", oen, 1);
                    if (k <= WE_LOW) begin
                        check(!wen, "R4", "write strobe low", wen, 0);
                        check(dq == d, "R4", "data on bus", dq, d);
                    end else begin
                        check(wen, "R5", "strobe high in tail", wen, 1);
                        check(dq == d, "R5", "data held in tail", dq, d);
                    end
                end else begin
                    check(!oen && wen, "R3", "read strobes", {oen, wen}, 2'b01);
                end
            end else if (k == len + 1) begin
                check(ack, "R8", "ack timing", ack, 1);
                check(s_n && !s_p, "R2", "deselect after access", {s_n, s_p}, 2'b10);
                check(oen && wen, "R6", "strobes idle", {oen, wen}, 2'b11);
            end else begin
                check(!ack && s_n, "R8", "held request not re-taken", {ack, s_n}, 2'b01);
                req = 1'b0;
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        check(s_n && !s_p, "R1", "selects in reset", {s_n, s_p}, 2'b10);
        check(oen && wen, "R1", "strobes in reset", {oen, wen}, 2'b11);
        check(!ack, "R1", "ack in reset", ack, 0);
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        check(s_n && !s_p && oen && wen && !ack, "R1", "first cycle after reset",
              {s_n, s_p, oen, wen, ack}, 5'b10110);

        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(s_n && !s_p, "R2", "idle deselected", {s_n, s_p}, 2'b10);
        end

        access(1'b1, 17'h00010, 8'hA5, 1'b1);
        access(1'b0, 17'h00010, 8'h00, 1'b1);
        access(1'b0, 17'h1FFFF, 8'h00, 1'b0);   // unwritten location
        access(1'b1, 17'h1FFFF, 8'h3C, 1'b0);   // R7: write right after read
        access(1'b0, 17'h1FFFF, 8'h00, 1'b1);

        for (int i = 0; i < 12; i++)
            access(1'b1, 17'(i * 11213 + 5), 8'(i * 29 + 3), i[0]);
        for (int i = 11; i >= 0; i--)
            access(1'b0, 17'(i * 11213 + 5), 8'h00, !i[0]);

        access(1'b1, 17'h0ABCD, 8'h11, 1'b1);
        access(1'b1, 17'h0ABCD, 8'hEE, 1'b0);
        access(1'b0, 17'h0ABCD, 8'h00, 1'b0);
        access(1'b0, 17'h00000, 8'h00, 1'b1);

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R8", "acks outstanding", sbq.size(), 0);
        check(s_n && !s_p, "R2", "idle at end", {s_n, s_p}, 2'b10);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule